// File: doc/BRIEF.md
# Asynchronous SRAM Write Timing Monitor

This block watches the control, address and data pins of an asynchronous static RAM. It does so from the side and never drives them. It samples every pin on a fast reference clock. Each sampled pin passes through a two-flop synchronizer before any edge is detected. Every edge of interest is stamped with the value of a free-running tick counter. When a write closes, the monitor compares the age of each stored stamp against minimum limits. Each limit is a parameter given in reference-clock ticks.

A write is the span in which chip select and write enable are both low. It ends at the first tick in which either of them is high again. Every "before the end" measurement is taken back from that tick. The two-flop delay is the same on every pin, so it cancels out of all the measured differences.

Each kind of violation sets its own sticky flag. Writes are counted as they close. A synchronous clear input zeroes the flags and the counter.

Top module: `wtc_monitor`

## Requirements
- R1: A write closes in the sampled tick where chip select and write enable were both low in the previous tick and at least one of them is now high. Each close adds exactly one to `write_count`.
- R2: At a close, if the strobes overlapped for fewer than `T_WP` ticks, `err_pulse` is set. The overlap is counted from the tick both were first low up to the closing tick.
- R3: At a close, if chip select last went low fewer than `T_CW` ticks earlier, `err_select` is set.
- R4: At a close, if the address last changed fewer than `T_AW` ticks earlier, `err_addr_age` is set. An address change in the closing tick itself counts as age 0.
- R5: At a close, if the data last changed fewer than `T_DW` ticks earlier, `err_data_age` is set.
- R6: `err_addr_move` is set when the address changes in a tick where the window was already open in the previous tick and is still open. A change in the opening tick or the closing tick is allowed. So is a change after the earlier strobe has risen while the other strobe is still low.
- R7: `err_cycle` is set when two successive address changes are fewer than `T_WC` ticks apart. The first address change after reset is exempt.
- R8: Every flag stays set until `clr` is asserted. While `clr` is high, all flags and `write_count` are zero on the next edge, whatever else happens in that tick.
- R9: Synchronous reset clears every flag and `write_count`.
- R10: A write in which every measured quantity equals its minimum exactly raises no flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference sample clock |
| rst | input | 1 | Synchronous active-high reset |
| clr | input | 1 | Clears all flags and the write counter |
| cs_n | input | 1 | Sampled chip select pin, active low |
| we_n | input | 1 | Sampled write enable pin, active low |
| addr | input | AW | Sampled address pins |
| data | input | DW | Sampled data pins |
| err_pulse | output | 1 | Sticky: strobe overlap too short (R2) |
| err_select | output | 1 | Sticky: chip select low too briefly before close (R3) |
| err_addr_age | output | 1 | Sticky: address too young at close (R4) |
| err_data_age | output | 1 | Sticky: data too young at close (R5) |
| err_addr_move | output | 1 | Sticky: address moved inside the window (R6) |
| err_cycle | output | 1 | Sticky: address cycle too short (R7) |
| write_count | output | CNT_W | Number of completed writes since reset or clear |

## Verification
The bench builds the monitor with 4-bit address and data, a 12-bit stamp and limits of 4, 4, 4, 3 and 5 ticks. With limits this small, a full sweep of address age, data age, chip select lead and write pulse width from 1 to 6 ticks crosses every threshold on both sides. The same sweep covers every ordering of the two falling strobes. The short stamp wraps several times during the run, which tests the modulo arithmetic of the ages. Directed sequences cover a window closed by chip select alone, the cycle-time limit on both sides, stickiness, and counting without clears.

// File: rtl/wtc_pkg.sv
package wtc_pkg;
  // Indices of the stamped events
  localparam int EV_ADDR = 0;
  localparam int EV_DATA = 1;
  localparam int EV_CS   = 2;
  localparam int EV_WIN  = 3;
  localparam int NUM_EV  = 4;

  typedef struct packed {
    logic cycle;
    logic addr_move;
    logic data_age;
    logic addr_age;
    logic select;
    logic pulse;
  } wtc_err_t;

  typedef struct packed {
    logic addr_chg;
    logic data_chg;
    logic cs_fall;
    logic win_open;
    logic win_close;
    logic win_held;
  } wtc_ev_t;
endpackage

// File: rtl/wtc_sync.sv
module wtc_sync #(
  parameter int             W    = 1,
  parameter logic [W-1:0]   INIT = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] meta_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      meta_q <= INIT;
      q      <= INIT;
    end else begin
      meta_q <= d;
      q      <= meta_q;
    end
  end
endmodule

// File: rtl/wtc_edge.sv
module wtc_edge
  import wtc_pkg::*;
#(
  parameter int AW = 12,
  parameter int DW = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cs_s,
  input  logic          we_s,
  input  logic [AW-1:0] addr_s,
  input  logic [DW-1:0] data_s,
  output wtc_ev_t       ev
);
  logic          cs_p, we_p;
  logic [AW-1:0] addr_p;
  logic [DW-1:0] data_p;
  logic          open_s, open_p;

  // Previous-tick copy; reset values match the synchronizer so no edge is seen at start
  always_ff @(posedge clk) begin
    if (rst) begin
      cs_p   <= 1'b1;
      we_p   <= 1'b1;
      addr_p <= '0;
      data_p <= '0;
    end else begin
      cs_p   <= cs_s;
      we_p   <= we_s;
      addr_p <= addr_s;
      data_p <= data_s;
    end
  end

  assign open_s = ~cs_s & ~we_s;
  assign open_p = ~cs_p & ~we_p;

  always_comb begin
    ev.addr_chg  = (addr_s != addr_p);
    ev.data_chg  = (data_s != data_p);
    ev.cs_fall   = cs_p & ~cs_s;
    ev.win_open  = open_s & ~open_p;
    ev.win_close = open_p & ~open_s;
    ev.win_held  = open_p & open_s;
  end
endmodule

// File: rtl/wtc_stamp.sv
module wtc_stamp
  import wtc_pkg::*;
#(
  parameter int TSW = 32
) (
  input  logic                       clk,
  input  logic                       rst,
  input  wtc_ev_t                    ev,
  output logic [NUM_EV-1:0][TSW-1:0] age,
  output logic                       seen_addr,
  output logic                       seen_data
);
  logic [TSW-1:0]    now_q;
  logic [NUM_EV-1:0] hit;

  always_ff @(posedge clk) begin
    if (rst) now_q <= '0;
    else     now_q <= now_q + 1'b1;
  end

  always_comb begin
    hit          = '0;
    hit[EV_ADDR] = ev.addr_chg;
    hit[EV_DATA] = ev.data_chg;
    hit[EV_CS]   = ev.cs_fall;
    hit[EV_WIN]  = ev.win_open;
  end

  // One stamp register per event kind; age is raw modulo difference to now
  for (genvar i = 0; i < NUM_EV; i++) begin : g_stamp
    logic [TSW-1:0] stamp_q;
    always_ff @(posedge clk) begin
      if (rst)         stamp_q <= '0;
      else if (hit[i]) stamp_q <= now_q;
    end
    assign age[i] = now_q - stamp_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      seen_addr <= 1'b0;
      seen_data <= 1'b0;
    end else begin
      if (ev.addr_chg) seen_addr <= 1'b1;
      if (ev.data_chg) seen_data <= 1'b1;
    end
  end
endmodule

// File: rtl/wtc_rules.sv
module wtc_rules
  import wtc_pkg::*;
#(
  parameter int TSW   = 32,
  parameter int CNT_W = 16,
  parameter int T_WP  = 4,
  parameter int T_CW  = 4,
  parameter int T_AW  = 4,
  parameter int T_DW  = 3,
  parameter int T_WC  = 5
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       clr,
  input  wtc_ev_t                    ev,
  input  logic [NUM_EV-1:0][TSW-1:0] age,
  input  logic                       seen_addr,
  input  logic                       seen_data,
  output wtc_err_t                   flags,
  output logic [CNT_W-1:0]           count
);
  localparam logic [TSW-1:0] LIM_WP = TSW'(T_WP);
  localparam logic [TSW-1:0] LIM_CW = TSW'(T_CW);
  localparam logic [TSW-1:0] LIM_AW = TSW'(T_AW);
  localparam logic [TSW-1:0] LIM_DW = TSW'(T_DW);
  localparam logic [TSW-1:0] LIM_WC = TSW'(T_WC);

  logic [TSW-1:0] addr_age_eff, data_age_eff;
  wtc_err_t       viol;

  // A change in the current tick has age zero; the stored stamp is not yet updated
  assign addr_age_eff = ev.addr_chg ? '0 : age[EV_ADDR];
  assign data_age_eff = ev.data_chg ? '0 : age[EV_DATA];

  always_comb begin
    viol.pulse     = ev.win_close && (age[EV_WIN] < LIM_WP);
    viol.select    = ev.win_close && (age[EV_CS]  < LIM_CW);
    viol.addr_age  = ev.win_close && (seen_addr || ev.addr_chg) && (addr_age_eff < LIM_AW);
    viol.data_age  = ev.win_close && (seen_data || ev.data_chg) && (data_age_eff < LIM_DW);
    viol.addr_move = ev.win_held && ev.addr_chg;
    viol.cycle     = ev.addr_chg && seen_addr && (age[EV_ADDR] < LIM_WC);
  end

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      flags <= '0;
      count <= '0;
    end else begin
      flags <= flags | viol;
      if (ev.win_close) count <= count + 1'b1;
    end
  end
endmodule

// File: rtl/wtc_monitor.sv
module wtc_monitor
  import wtc_pkg::*;
#(
  parameter int AW    = 12,
  parameter int DW    = 4,
  parameter int TSW   = 32,
  parameter int CNT_W = 16,
  parameter int T_WP  = 4,
  parameter int T_CW  = 4,
  parameter int T_AW  = 4,
  parameter int T_DW  = 3,
  parameter int T_WC  = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic             cs_n,
  input  logic             we_n,
  input  logic [AW-1:0]    addr,
  input  logic [DW-1:0]    data,
  output logic             err_pulse,
  output logic             err_select,
  output logic             err_addr_age,
  output logic             err_data_age,
  output logic             err_addr_move,
  output logic             err_cycle,
  output logic [CNT_W-1:0] write_count
);
  localparam int PW = 2 + AW + DW;
  localparam logic [PW-1:0] PIN_INIT = {2'b11, {(AW + DW){1'b0}}};

  logic [PW-1:0]              pins_s;
  logic                       cs_s, we_s;
  logic [AW-1:0]              addr_s;
  logic [DW-1:0]              data_s;
  wtc_ev_t                    ev;
  logic [NUM_EV-1:0][TSW-1:0] age;
  logic                       seen_addr, seen_data;
  wtc_err_t                   flags;

  wtc_sync #(.W(PW), .INIT(PIN_INIT)) u_sync (
    .clk (clk),
    .rst (rst),
    .d   ({cs_n, we_n, addr, data}),
    .q   (pins_s)
  );

  assign {cs_s, we_s, addr_s, data_s} = pins_s;

  wtc_edge #(.AW(AW), .DW(DW)) u_edge (
    .clk    (clk),
    .rst    (rst),
    .cs_s   (cs_s),
    .we_s   (we_s),
    .addr_s (addr_s),
    .data_s (data_s),
    .ev     (ev)
  );

  wtc_stamp #(.TSW(TSW)) u_stamp (
    .clk       (clk),
    .rst       (rst),
    .ev        (ev),
    .age       (age),
    .seen_addr (seen_addr),
    .seen_data (seen_data)
  );

  wtc_rules #(
    .TSW(TSW), .CNT_W(CNT_W), .T_WP(T_WP), .T_CW(T_CW),
    .T_AW(T_AW), .T_DW(T_DW), .T_WC(T_WC)
  ) u_rules (
    .clk       (clk),
    .rst       (rst),
    .clr       (clr),
    .ev        (ev),
    .age       (age),
    .seen_addr (seen_addr),
    .seen_data (seen_data),
    .flags     (flags),
    .count     (write_count)
  );

  assign err_pulse     = flags.pulse;
  assign err_select    = flags.select;
  assign err_addr_age  = flags.addr_age;
  assign err_data_age  = flags.data_age;
  assign err_addr_move = flags.addr_move;
  assign err_cycle     = flags.cycle;
endmodule

// File: rtl/wtc_monitor_chk.sv
module wtc_monitor_chk #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst,
  input logic             clr,
  input logic [5:0]       errs,
  input logic [CNT_W-1:0] write_count
);
  // R8: a set flag is never dropped without a clear
  p_sticky_flags_r8: assert property (@(posedge clk) disable iff (rst)
    !clr |=> ((errs & $past(errs)) == $past(errs)));

  // R8: clear empties flags and counter on the next edge
  p_clear_all_r8: assert property (@(posedge clk) disable iff (rst)
    clr |=> (errs == '0 && write_count == '0));

  // R9: reset leaves everything zero
  p_reset_zero_r9: assert property (@(posedge clk)
    rst |=> (errs == '0 && write_count == '0));

  // R1: the write counter only ever advances by one
  p_count_step_r1: assert property (@(posedge clk) disable iff (rst)
    !clr |=> (write_count == $past(write_count) ||
              write_count == $past(write_count) + 1'b1));
endmodule

bind wtc_monitor wtc_monitor_chk #(.CNT_W(CNT_W)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .clr         (clr),
  .errs        ({err_cycle, err_addr_move, err_data_age, err_addr_age, err_select, err_pulse}),
  .write_count (write_count)
);

// File: tb/wtc_monitor_tb_top.sv
module wtc_monitor_tb_top;
  localparam int AW = 4, DW = 4, TSW = 12, CNT_W = 8;
  localparam int T_WP = 4, T_CW = 4, T_AW = 4, T_DW = 3, T_WC = 5;

  logic clk = 1'b0;
  logic rst = 1'b1, clr = 1'b0;
  logic cs_n = 1'b1, we_n = 1'b1;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] data = '0;
  logic e_pulse, e_select, e_aage, e_dage, e_amove, e_cycle;
  logic [CNT_W-1:0] write_count;

  int checks = 0, fails = 0;
  int tnow = 0, last_addr_t = -1;

  always #5 clk = ~clk;

  wtc_monitor #(.AW(AW), .DW(DW), .TSW(TSW), .CNT_W(CNT_W), .T_WP(T_WP),
    .T_CW(T_CW), .T_AW(T_AW), .T_DW(T_DW), .T_WC(T_WC)) dut_i (
    .clk(clk), .rst(rst), .clr(clr), .cs_n(cs_n), .we_n(we_n),
    .addr(addr), .data(data), .err_pulse(e_pulse), .err_select(e_select),
    .err_addr_age(e_aage), .err_data_age(e_dage), .err_addr_move(e_amove),
    .err_cycle(e_cycle), .write_count(write_count));

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
    tnow++;
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) step();
  endtask

  task automatic new_addr();
    addr = addr + 1'b1;
    last_addr_t = tnow;
  endtask

  task automatic do_clear();
    clr = 1'b1;
    step();
    clr = 1'b0;
  endtask

  task automatic check_flags(string tag, int wp, int cw, int aa, int da, int am, int cy);
    check({tag, " R2 pulse"},     e_pulse,  wp);
    check({tag, " R3 select"},    e_select, cw);
    check({tag, " R4 addr age"},  e_aage,   aa);
    check({tag, " R5 data age"},  e_dage,   da);
    check({tag, " R6 addr move"}, e_amove,  am);
    check({tag, " R7 cycle"},     e_cycle,  cy);
  endtask

  // Write closed by both strobes rising together at tick C; ages counted back from C
  task automatic do_write(int a_age, int d_age, int cs_age, int wp);
    int lead;
    lead = a_age;
    if (d_age > lead)  lead = d_age;
    if (cs_age > lead) lead = cs_age;
    if (wp > lead)     lead = wp;
    lead++;
    for (int t = lead; t >= 1; t--) begin
      if (t == a_age)  new_addr();
      if (t == d_age)  data = data + 1'b1;
      if (t == cs_age) cs_n = 1'b0;
      if (t == wp)     we_n = 1'b0;
      step();
    end
    cs_n = 1'b1;
    we_n = 1'b1;
    idle(4);
  endtask

  initial begin
    idle(3);
    rst = 1'b0;
    idle(3);
    // R9: reset state
    check_flags("reset R9", 0, 0, 0, 0, 0, 0);
    check("R9 count after reset", write_count, 0);

    // R10: every quantity exactly at its minimum
    do_write(T_AW, T_DW, T_CW, T_WP);
    check_flags("boundary R10", 0, 0, 0, 0, 0, 0);
    check("R1 count after one write", write_count, 1);
    do_clear();

    // R6: window closed by chip select; address moves while write enable still low
    new_addr(); step(); idle(5);
    data = data + 1'b1; idle(4);
    cs_n = 1'b0; step();
    we_n = 1'b0; idle(5);
    cs_n = 1'b1; step();
    new_addr(); step(); idle(2);
    we_n = 1'b1; idle(5);
    check_flags("select-closed R6", 0, 0, 0, 0, 0, 0);
    check("R1 select-closed count", write_count, 1);
    do_clear();

    // R7: address cycle one short, then exactly the minimum
    idle(6);
    new_addr(); idle(T_WC - 1);
    new_addr(); idle(4);
    check("R7 short cycle", e_cycle, 1);
    do_clear();
    idle(6);
    new_addr(); idle(T_WC);
    new_addr(); idle(4);
    check("R7 exact cycle", e_cycle, 0);
    do_clear();

    // R8: a violation survives a later clean write
    do_write(6, 6, 6, 2);
    do_write(6, 6, 6, 6);
    check("R8 sticky pulse", e_pulse, 1);
    check("R1 two writes counted", write_count, 2);
    do_write(6, 6, 6, 6);
    check("R1 three writes counted", write_count, 3);
    do_clear();
    idle(1);
    check("R8 clear flag", e_pulse, 0);
    check("R8 clear count", write_count, 0);

    // Sweep of ages, chip select lead and pulse width
    for (int a = 1; a <= 6; a++)
      for (int d = 1; d <= 6; d++)
        for (int c = 1; c <= 6; c++)
          for (int w = 1; w <= 6; w++) begin
            int open_age;
            open_age = (c < w) ? c : w;
            do_write(a, d, c, w);
            check_flags("sweep", int'(open_age < T_WP), int'(c < T_CW),
                        int'(a < T_AW), int'(d < T_DW), int'(a < open_age), 0);
            check("R1 sweep count", write_count, 1);
            do_clear();
          end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule